// File: doc/BRIEF.md
# Full-Scan Test Sequencer

This block wraps a bank of state registers that sits between two combinational logic clouds. Each register stage is a mux-D scan cell. In functional mode every stage loads its functional input on each clock. In test mode all stages are linked into a single serial chain. The chain runs from an internal serial input to the `scan_out` pin.

A sequencing controller runs a full scan test with no outside help. A `start` pulse latches a test vector. The controller then shifts that vector into the chain over N clocks and allows a single functional capture clock. It then shifts the captured response out over N more clocks while collecting it into a parallel result register. A one-cycle `done` pulse marks the end of the test.

The combinational clouds are not part of the block. `func_q` feeds the downstream logic, and `func_d` carries the upstream logic's result back into the stages.

Top module: `scan_test_engine`

## Requirements
- R1: While no test is running (`busy` low, `done` low), every clock loads `func_d` into the register bank, so `func_q` equals the `func_d` of the previous cycle.
- R2: While `scan_en` is high, each clock moves stage i-1 into stage i, and stage 0 takes the serial input bit. `scan_out` is stage N-1.
- R3: Loading takes exactly N clocks with `scan_en` high. The most significant vector bit enters first, so afterwards `func_q` equals the latched vector bit for bit.
- R4: After loading, exactly one clock has `scan_en` low while `busy` is high. On that clock `func_d` is captured into the bank.
- R5: After capture, N clocks with `scan_en` high unload the chain. Stage N-1 leaves first. `response[i]` receives the value captured in stage i. In total `scan_en` is high for 2N cycles per test.
- R6: `done` is high for exactly one cycle. It is sampled high 2N+1 clocks after the clock edge that accepts `start`. `response` holds its value after `done` until the next unload.
- R7: A `start` pulse or a change of `test_vector` while a test runs has no effect. The running test keeps its timing and its result.
- R8: A synchronous active-high `rst` returns the controller to idle and clears the chain and `response`. `busy`, `done` and `scan_en` read 0 afterwards.
- R9: `busy` is high from the cycle after `start` is accepted through the last unload cycle, which is 2N+1 cycles in all. It is low in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run one scan test (accepted only when idle) |
| test_vector | input | WIDTH | Pattern to load into the chain |
| func_d | input | WIDTH | Functional inputs from the upstream logic cloud |
| func_q | output | WIDTH | Register bank outputs to the downstream logic cloud |
| scan_out | output | 1 | Serial output of the last chain stage |
| scan_en | output | 1 | Test-select applied to every scan cell |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| response | output | WIDTH | Unloaded capture result, bit i from stage i |

## Verification
The bench stands in for the logic cloud with a rotate-and-xor function. The test vectors are all zeros and all ones, a single one at the lowest and at the highest position, alternating bits, and two mixed blocks. The single-bit vectors show whether the load and the unload run in the right direction, because a reversed chain or a reversed response index moves the lone bit to the wrong end. The all-zero and all-one vectors reveal stuck serial paths. The alternating and mixed vectors expose a capture that is skipped or taken on the wrong cycle. A test with a mid-run start pulse and a changed vector, and another cut short by reset, cover the ignore and clear rules.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_IN,
        ST_CAPTURE,
        ST_SHIFT_OUT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic scan_en;
        logic scan_bit;
        logic unload;
        logic done;
        logic busy;
    } seq_ctrl_t;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst,
    input  logic sel_scan,
    input  logic d_func,
    input  logic d_scan,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= sel_scan ? d_scan : d_func;
    end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_en,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] func_d,
    output logic [WIDTH-1:0] q,
    output logic             scan_out
);
    logic [WIDTH:0] link;

    assign link[0] = scan_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        scan_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .sel_scan (scan_en),
            .d_func   (func_d[i]),
            .d_scan   (link[i]),
            .q        (q[i])
        );
        assign link[i+1] = q[i];
    end

    assign scan_out = link[WIDTH];

    // R2: serial shift moves each stage up by one
    a_r2_shift_upper: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
    a_r2_shift_entry: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> q[0] == $past(scan_in));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned CW = cnt_bits(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] vector,
    output seq_ctrl_t        ctl,
    output logic [CW-1:0]    bit_idx
);
    localparam logic [CW-1:0] CNT_MAX = CW'(WIDTH - 1);

    seq_state_e       state;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] vec_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            vec_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SHIFT_IN;
                        cnt   <= CNT_MAX;
                        vec_r <= vector;
                    end
                end
                ST_SHIFT_IN: begin
                    if (cnt == '0) state <= ST_CAPTURE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_CAPTURE: begin
                    state <= ST_SHIFT_OUT;
                    cnt   <= CNT_MAX;
                end
                ST_SHIFT_OUT: begin
                    if (cnt == '0) state <= ST_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.scan_en  = (state == ST_SHIFT_IN) || (state == ST_SHIFT_OUT);
        ctl.scan_bit = (state == ST_SHIFT_IN) ? vec_r[cnt] : 1'b0;
        ctl.unload   = (state == ST_SHIFT_OUT);
        ctl.done     = (state == ST_DONE);
        ctl.busy     = (state != ST_IDLE) && (state != ST_DONE);
    end

    assign bit_idx = cnt;

    // R3: the load phase counts down one step per clock
    a_r3_load_count: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT_IN && cnt != '0) |=> state == ST_SHIFT_IN && cnt == $past(cnt) - 1'b1);
    // R4: capture lasts a single cycle, then the unload starts at the top
    a_r4_capture_once: assert property (@(posedge clk) disable iff (rst)
        state == ST_CAPTURE |=> state == ST_SHIFT_OUT && cnt == CNT_MAX);
    // R6: the done state is left after one cycle
    a_r6_done_leave: assert property (@(posedge clk) disable iff (rst)
        state == ST_DONE |=> state == ST_IDLE);
    // R7: the latched vector is frozen while a test runs
    a_r7_vector_held: assert property (@(posedge clk) disable iff (rst)
        state != ST_IDLE |=> vec_r == $past(vec_r));
    // R8: reset brings the controller back to idle
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> state == ST_IDLE && cnt == '0);
endmodule

// File: rtl/scan_unload.sv
module scan_unload #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unload,
    input  logic [CW-1:0]    bit_idx,
    input  logic             scan_out,
    output logic [WIDTH-1:0] resp
);
    always_ff @(posedge clk) begin
        if (rst)
            resp <= '0;
        else if (unload)
            resp[bit_idx] <= scan_out;
    end

    // R5: the final unload step fills bit 0 from the serial output
    a_r5_last_bit: assert property (@(posedge clk) disable iff (rst)
        (unload && bit_idx == '0) |=> resp[0] == $past(scan_out));
    // R6: result is held outside the unload phase
    a_r6_resp_hold: assert property (@(posedge clk) disable iff (rst)
        !unload |=> $stable(resp));
endmodule

// File: rtl/scan_test_engine.sv
module scan_test_engine
    import scan_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] test_vector,
    input  logic [WIDTH-1:0] func_d,
    output logic [WIDTH-1:0] func_q,
    output logic             scan_out,
    output logic             scan_en,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] response
);
    localparam int unsigned CW = cnt_bits(WIDTH);

    seq_ctrl_t     ctl;
    logic [CW-1:0] bit_idx;

    scan_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .vector  (test_vector),
        .ctl     (ctl),
        .bit_idx (bit_idx)
    );

    scan_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (ctl.scan_en),
        .scan_in  (ctl.scan_bit),
        .func_d   (func_d),
        .q        (func_q),
        .scan_out (scan_out)
    );

    scan_unload #(.WIDTH(WIDTH), .CW(CW)) u_unload (
        .clk      (clk),
        .rst      (rst),
        .unload   (ctl.unload),
        .bit_idx  (bit_idx),
        .scan_out (scan_out),
        .resp     (response)
    );

    assign scan_en = ctl.scan_en;
    assign busy    = ctl.busy;
    assign done    = ctl.done;

    // R1: functional mode loads the functional inputs
    a_r1_functional: assert property (@(posedge clk) disable iff (rst)
        (!busy && !scan_en) |=> func_q == $past(func_d));
    // R4: the capture cycle inside a test loads the functional inputs
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        (busy && !scan_en) |=> func_q == $past(func_d));
    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9: done never overlaps busy or shifting
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !scan_en);
endmodule

// File: tb/tb_scan_test_engine.sv
`timescale 1ns/1ps
module tb_scan_test_engine;
    localparam int unsigned N = 8;
    localparam logic [N-1:0] MASK = 8'hA5;
    localparam int NVEC = 7;
    // {test vector, expected response}
    localparam logic [2*N-1:0] VEC_TAB [NVEC] = '{
        16'h00_A5, 16'hFF_5A, 16'h01_A7, 16'h80_A4,
        16'h55_0F, 16'hC3_22, 16'h3C_DD
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N-1:0] test_vector = '0;
    logic [N-1:0] func_d, func_q, response;
    logic scan_out, scan_en, busy, done;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [N-1:0] cloud(input logic [N-1:0] x);
        return {x[N-2:0], x[N-1]} ^ MASK;
    endfunction

    assign func_d = cloud(func_q);

    scan_test_engine #(.WIDTH(N)) dut (
        .clk(clk), .rst(rst), .start(start), .test_vector(test_vector),
        .func_d(func_d), .func_q(func_q), .scan_out(scan_out),
        .scan_en(scan_en), .busy(busy), .done(done), .response(response)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_test(input logic [N-1:0] vec, input logic [N-1:0] exp, input bit inject);
        int se_cnt;
        int bz_cnt;
        bit shift_ok;
        bit sout_ok;
        bit early_done;
        logic [N-1:0] prev;
        @(negedge clk);
        test_vector = vec;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        se_cnt = int'(scan_en);
        bz_cnt = int'(busy);
        shift_ok = 1'b1;
        sout_ok = 1'b1;
        early_done = done;
        prev = func_q;
        for (int k = 1; k <= 2*N+1; k++) begin
            @(negedge clk);
            if (inject && k == 3) begin
                start = 1'b1;
                test_vector = ~vec;
            end else if (inject && k == 4) begin
                start = 1'b0;
            end
            se_cnt += int'(scan_en);
            bz_cnt += int'(busy);
            if (k <= N-1 && func_q[N-1:1] != prev[N-2:0]) shift_ok = 1'b0;
            if (k == N) begin
                check("R3 loaded bank", func_q, vec);
                check("R4 scan_en low at capture", scan_en, 1'b0);
            end
            if (k == N+1) check("R4 captured bank", func_q, exp);
            if (k >= N+1 && k <= 2*N && scan_out !== exp[2*N-k]) sout_ok = 1'b0;
            if (k < 2*N+1 && done) early_done = 1'b1;
            prev = func_q;
        end
        check("R2 shift order during load", shift_ok, 1'b1);
        check("R5 scan_out order", sout_ok, 1'b1);
        check("R6 no early done", early_done, 1'b0);
        check("R6 done at 2N+1", done, 1'b1);
        check("R5 scan_en cycles", se_cnt, 2*N);
        check("R9 busy cycles", bz_cnt, 2*N+1);
        check(inject ? "R7 response after ignored start" : "R5 response", response, exp);
        @(negedge clk);
        check("R6 done one cycle", done, 1'b0);
        check("R6 response held", response, exp);
        check("R7 idle after test", busy, 1'b0);
        test_vector = '0;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [N-1:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 reset bank", func_q, '0);
        check("R8 reset busy", busy, 1'b0);
        check("R8 reset done", done, 1'b0);
        check("R8 reset scan_en", scan_en, 1'b0);
        check("R8 reset response", response, '0);

        // R1: functional mode
        for (int i = 0; i < 4; i++) begin
            prev = func_q;
            @(negedge clk);
            check("R1 functional load", func_q, cloud(prev));
        end

        for (int i = 0; i < NVEC; i++)
            run_test(VEC_TAB[i][2*N-1:N], VEC_TAB[i][N-1:0], 1'b0);

        // R7: start and vector change mid-test are ignored
        run_test(8'h3C, cloud(8'h3C), 1'b1);
        run_test(8'h01, cloud(8'h01), 1'b0);

        // R8: reset in the middle of a test
        @(negedge clk);
        test_vector = 8'h80;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-test reset busy", busy, 1'b0);
        check("R8 mid-test reset scan_en", scan_en, 1'b0);
        check("R8 mid-test reset bank", func_q, '0);
        check("R8 mid-test reset response", response, '0);
        rst = 1'b0;
        run_test(8'hC3, cloud(8'hC3), 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule